// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the scan position, the two sync strobes and the visible-area qualifier for a raster display. A simple write port programs it. Each axis, horizontal and vertical, has a period, a last visible index, a sync start and a sync length. One control word holds a run bit, a plane bit and one polarity bit for each sync. The counters advance at one position per clock, so the clock is the pixel clock.

Software writes the eight geometry words into a shadow bank. The active bank takes that copy only when a frame ends, or on every cycle while timing is stopped. A frame therefore never mixes two geometries. The control word takes effect on the clock after it is written. All outputs are registered, and the counters and strobes that leave the block on the same cycle describe the same scan position.

Top module: `raster_timing_gen`

## Requirements
- R1: After synchronous reset, the control word and both geometry banks are zero, both counters read 0, display enable is low, and hsync and vsync are at the inactive level of polarity 0, which is 1.
- R2: The horizontal period word holds the line length minus one. The horizontal counter steps by one each clock and returns to 0 on the clock after it equals that word.
- R3: The vertical counter steps once each time the horizontal counter wraps. The vertical period word holds the line count minus one, and the vertical counter returns to 0 after the line whose index equals that word.
- R4: Display enable is high when timing runs, the plane bit is set, the horizontal count is at most the horizontal last-visible word and the vertical count is at most the vertical last-visible word. Each last-visible word holds the visible count minus one.
- R5: A sync start word holds the start position minus one, and a sync length word holds the plain length. Hsync is asserted for horizontal counts from start word plus 1 up to start word plus length. Vsync is asserted for vertical counts in the same window built from the vertical words.
- R6: Control bit 2 sets the hsync polarity and control bit 3 sets the vsync polarity. A polarity of 1 drives the asserted level high, and a polarity of 0 drives it low. The idle level is always the complement of the asserted level.
- R7: While control bit 0 (run) is clear, both counters are held at 0, both syncs sit at their idle level and display enable is low.
- R8: While control bit 1 (plane) is clear, display enable stays low even though the counters and syncs keep running.
- R9: Geometry writes go to the shadow bank. The active bank copies the shadow bank on the clock where both counters wrap together, and on every clock while run is clear. A control write takes effect on the next clock.
- R10: The write map is as follows. Address 0 is the control word. Addresses 1 to 4 hold the horizontal period, last visible, sync start and sync length. Addresses 5 to 8 hold the same four vertical words. Only the low CW data bits are kept. Writes to addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word address |
| wr_data | input | DW | Write data |
| h_count | output | CW | Horizontal scan position |
| v_count | output | CW | Vertical scan position |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Visible-area qualifier |

## Verification
The bench goes after the minus-one conventions. A design that treats the period or start word as the raw value stretches each line by one clock, or shifts the sync pulse by one pixel. A design that offsets the length word produces a pulse one pixel too short or too long. The main hazard is a geometry rewrite in the middle of a frame: a design without shadow banking changes the line length inside the current frame, and one that copies on a line wrap instead of a frame wrap changes the geometry one line later. The bench also drops run and plane during a scan. A design that lets the counters coast on, or leaves the syncs at the asserted level, shows up at once. The unused addresses are written to confirm that a loose decode cannot corrupt the geometry.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // Control word bit positions
  localparam int unsigned CTL_RUN   = 0;
  localparam int unsigned CTL_PLANE = 1;
  localparam int unsigned CTL_HPOL  = 2;
  localparam int unsigned CTL_VPOL  = 3;
  localparam int unsigned CTL_BITS  = 4;

  // Geometry word slots (write address = slot + 1)
  typedef enum logic [2:0] {
    G_HPER = 3'd0,
    G_HVIS = 3'd1,
    G_HSST = 3'd2,
    G_HSLN = 3'd3,
    G_VPER = 3'd4,
    G_VVIS = 3'd5,
    G_VSST = 3'd6,
    G_VSLN = 3'd7
  } geo_slot_e;

  localparam int unsigned GEO_WORDS = 8;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile #(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          wr_en,
  input  logic [AW-1:0]                                 wr_addr,
  input  logic [DW-1:0]                                 wr_data,
  input  logic                                          load,
  output logic [rtg_pkg::CTL_BITS-1:0]                  ctrl,
  output logic [rtg_pkg::GEO_WORDS-1:0][CW-1:0]         geo
);
  import rtg_pkg::*;

  logic [GEO_WORDS-1:0][CW-1:0] shadow_q;
  logic [GEO_WORDS-1:0][CW-1:0] active_q;
  logic [CTL_BITS-1:0]          ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_en && wr_addr == AW'(0))
      ctrl_q <= wr_data[CTL_BITS-1:0];
  end

  for (genvar gi = 0; gi < GEO_WORDS; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        shadow_q[gi] <= '0;
      else if (wr_en && wr_addr == AW'(gi + 1))
        shadow_q[gi] <= wr_data[CW-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)
        active_q[gi] <= '0;
      else if (load)
        active_q[gi] <= shadow_q[gi];
    end
  end

  assign ctrl = ctrl_q;
  assign geo  = active_q;

  // R9: active bank only changes on a load clock
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active_q));
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] last,
  input  logic [CW-1:0] vis_end,
  input  logic [CW-1:0] sync_m1,
  input  logic [CW-1:0] sync_len,
  output logic [CW-1:0] count,
  output logic          wrap,
  output logic          in_vis,
  output logic          in_sync
);
  localparam int unsigned XW = CW + 1;

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_nxt;
  logic [XW-1:0] sync_lo;
  logic [XW-1:0] sync_hi;

  assign wrap = run && step && (count_q == last);

  always_comb begin
    if (!run)
      count_nxt = '0;
    else if (wrap)
      count_nxt = '0;
    else if (step)
      count_nxt = count_q + CW'(1);
    else
      count_nxt = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_nxt;
  end

  assign sync_lo = {1'b0, sync_m1} + XW'(1);
  assign sync_hi = sync_lo + {1'b0, sync_len};
  assign in_vis  = (count_nxt <= vis_end);
  assign in_sync = ({1'b0, count_nxt} >= sync_lo) && ({1'b0, count_nxt} < sync_hi);
  assign count   = count_q;

  // R2/R3: position never passes the programmed period
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count_q <= last);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] h_count,
  output logic [CW-1:0] v_count,
  output logic          hsync,
  output logic          vsync,
  output logic          de
);
  import rtg_pkg::*;

  logic [CTL_BITS-1:0]          ctrl;
  logic [GEO_WORDS-1:0][CW-1:0] geo;
  logic run, plane, hpol, vpol;
  logic h_wrap, v_wrap, h_vis, v_vis, h_syn, v_syn, load;
  logic hs_q, vs_q, de_q;

  assign run   = ctrl[CTL_RUN];
  assign plane = ctrl[CTL_PLANE];
  assign hpol  = ctrl[CTL_HPOL];
  assign vpol  = ctrl[CTL_VPOL];
  assign load  = !run || v_wrap;

  rtg_regfile #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .ctrl(ctrl), .geo(geo)
  );

  rtg_axis #(.CW(CW)) u_h (
    .clk(clk), .rst(rst), .run(run), .step(1'b1),
    .last(geo[G_HPER]), .vis_end(geo[G_HVIS]), .sync_m1(geo[G_HSST]), .sync_len(geo[G_HSLN]),
    .count(h_count), .wrap(h_wrap), .in_vis(h_vis), .in_sync(h_syn)
  );

  rtg_axis #(.CW(CW)) u_v (
    .clk(clk), .rst(rst), .run(run), .step(h_wrap),
    .last(geo[G_VPER]), .vis_end(geo[G_VVIS]), .sync_m1(geo[G_VSST]), .sync_len(geo[G_VSLN]),
    .count(v_count), .wrap(v_wrap), .in_vis(v_vis), .in_sync(v_syn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
      de_q <= 1'b0;
    end else begin
      hs_q <= (run && h_syn) ? hpol : !hpol;
      vs_q <= (run && v_syn) ? vpol : !vpol;
      de_q <= run && plane && h_vis && v_vis;
    end
  end

  assign hsync = hs_q;
  assign vsync = vs_q;
  assign de    = de_q;

  // R7: stopped timing parks counters, syncs and qualifier
  assert_idle_park_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (h_count == '0 && v_count == '0 && !de && hsync == !$past(hpol) && vsync == !$past(vpol)));

  // R8: qualifier requires the plane bit
  assert_plane_gate_R8: assert property (@(posedge clk) disable iff (rst)
    de |-> $past(plane));

  // R3: line counter only moves when a line starts
  assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(v_count) |-> h_count == '0);
endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
  localparam int CW = 12;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] h_count, v_count;
  logic hsync, vsync, de;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.CW(CW), .DW(DW), .AW(AW)) u_raster_timing_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_count(h_count), .v_count(v_count), .hsync(hsync), .vsync(vsync), .de(de)
  );

  // Requirement-level reference: control bits, shadow and active banks
  int m_ctl;
  int m_sh[8];
  int m_ac[8];
  int eh, ev;
  bit ehs, evs, ede;

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = 0;
      for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
      eh = 0; ev = 0; ehs = 1; evs = 1; ede = 0;
    end else begin
      bit run, pl, hp, vp, fe, hact, vact;
      int nh, nv;
      run = m_ctl[0]; pl = m_ctl[1]; hp = m_ctl[2]; vp = m_ctl[3];
      fe = run && eh == m_ac[0] && ev == m_ac[4];
      if (!run) begin nh = 0; nv = 0; end
      else if (eh == m_ac[0]) begin nh = 0; nv = (ev == m_ac[4]) ? 0 : ev + 1; end
      else begin nh = eh + 1; nv = ev; end
      hact = nh >= m_ac[2] + 1 && nh < m_ac[2] + 1 + m_ac[3];
      vact = nv >= m_ac[6] + 1 && nv < m_ac[6] + 1 + m_ac[7];
      ehs = (run && hact) ? hp : !hp;
      evs = (run && vact) ? vp : !vp;
      ede = run && pl && nh <= m_ac[1] && nv <= m_ac[5];
      if (!run || fe) for (int i = 0; i < 8; i++) m_ac[i] = m_sh[i];
      if (wr_en) begin
        if (wr_addr == 0) m_ctl = int'(wr_data[3:0]);
        else if (wr_addr <= 8) m_sh[wr_addr - 1] = int'(wr_data[CW-1:0]);
      end
      eh = nh; ev = nv;
    end
  end

  task automatic cmp(string tag);
    n_chk++;
    if (h_count !== CW'(eh) || v_count !== CW'(ev) || hsync !== ehs || vsync !== evs || de !== ede) begin
      n_bad++;
      $display("FAIL %s t=%0t: got h=%0d v=%0d hs=%b vs=%b de=%b, expected h=%0d v=%0d hs=%b vs=%b de=%b",
               tag, $time, h_count, v_count, hsync, vsync, de, eh, ev, ehs, evs, ede);
    end
  endtask

  task automatic cyc(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag);
    end
  endtask

  task automatic wr(int addr, int data, string tag);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = DW'(data);
    cyc(1, tag);
    wr_en = 1'b0;
  endtask

  // geometry in plain counts, converted to register conventions
  task automatic set_geo(int ht, int hv, int hs, int hw, int vt, int vv, int vs, int vh, string tag);
    wr(1, ht - 1, tag); wr(2, hv - 1, tag); wr(3, hs - 1, tag); wr(4, hw, tag);
    wr(5, vt - 1, tag); wr(6, vv - 1, tag); wr(7, vs - 1, tag); wr(8, vh, tag);
  endtask

  task automatic t_reset();
    cyc(4, "R1");
    n_chk++;
    if (h_count !== 0 || v_count !== 0 || hsync !== 1 || vsync !== 1 || de !== 0) begin
      n_bad++;
      $display("FAIL R1: got h=%0d v=%0d hs=%b vs=%b de=%b, expected 0 0 1 1 0", h_count, v_count, hsync, vsync, de);
    end
  endtask

  task automatic t_small_pos();
    set_geo(10, 6, 7, 2, 6, 4, 5, 1, "R10");
    wr(0, 4'b1111, "R9");
    cyc(130, "R2 R3 R4 R5 R6");
  endtask

  task automatic t_neg_noplane();
    wr(0, 0, "R7");
    set_geo(9, 5, 6, 3, 5, 3, 4, 2, "R10");
    wr(0, 4'b0001, "R6");
    cyc(100, "R6 R8");
  endtask

  task automatic t_shadow();
    wr(0, 0, "R7");
    set_geo(10, 6, 7, 2, 6, 4, 5, 1, "R10");
    wr(0, 4'b0011, "R9");
    cyc(23, "R9");
    wr(1, 7, "R9");
    wr(6, 1, "R9");
    wr(3, 4, "R9");
    cyc(150, "R9 R2 R4");
  endtask

  task automatic t_unused();
    for (int a = 9; a < 16; a++) wr(a, 32'h5a5 + a, "R10");
    cyc(70, "R10");
  endtask

  task automatic t_disable();
    wr(0, 4'b1100, "R7");
    cyc(20, "R7");
    wr(0, 4'b1111, "R7");
    cyc(40, "R7");
  endtask

  task automatic t_ref_modes();
    wr(0, 0, "R7");
    set_geo(1056, 800, 840, 128, 628, 600, 601, 4, "R10");
    wr(0, 4'b1111, "R5");
    cyc(3 * 1056 + 10, "R2 R5 R6");
    wr(0, 0, "R7");
    set_geo(800, 640, 656, 96, 525, 480, 490, 2, "R10");
    wr(0, 4'b0011, "R5");
    cyc(3 * 800 + 10, "R2 R5 R6");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_small_pos();
    t_neg_noplane();
    t_shadow();
    t_unused();
    t_disable();
    t_ref_modes();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule